// File: doc/BRIEF.md
# Vertical Line Expansion Filter

This block stretches a raster image vertically by blending each scan line with the line above it, for one colour component. A rate stage upstream has already repeated lines so that the line count in the stream equals the output line count. This block only has to work out, for each line, how much of the previous line and how much of the current line goes into each output sample. Pixels enter and leave on a valid/ready stream. Each pixel carries a start-of-line and a start-of-frame marker, and the markers come out aligned with the filtered pixel.

A two-bit mode input selects the ratio. Pass-through sends samples through unchanged. In the five-line cycle used for 4:5 expansion, weights step in quarters. In the three-line cycle used for 2:3 expansion, weights step in halves. The mode is taken at each frame start. A line buffer holds one full line, so each sample can be paired with the sample in the same column of the line before. The buffer size is set by the `LINE_W` parameter.

Back-pressure: `in_ready` is always equal to `out_ready`. The whole two-stage pipeline advances on a clock edge where `out_ready` is high, and holds completely on any other edge. An input pixel is accepted on an edge where `in_valid` and `in_ready` are both high. An output pixel is consumed on an edge where `out_valid` and `out_ready` are both high.

Top module: `vline_expand`

## Requirements
- R1: `in_ready` equals `out_ready` in every cycle. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_pix`, `out_sol` and `out_sof` hold their values.
- R2: A pixel accepted on an advancing edge appears on the output after the next advancing edge, and is consumed on the advancing edge after that (two advancing edges of latency). `out_sol` is high for a pixel that had either marker set, and `out_sof` copies the input frame marker. No output is valid when nothing was accepted two advancing edges earlier.
- R3: Mode code 0 and mode code 3 are pass-through: each output sample equals its input sample.
- R4: Mode code 1 (4:5) gives line phase k (0 to 4) the output round(((4-k)·P + k·C)/4). C is the current sample and P is the sample in the same column (pixel count since line start) of the previous accepted line.
- R5: Mode code 2 (2:3) gives line phase k (0 to 2) the output round(((2-k)·P + k·C)/2), with C and P as in R4.
- R6: Rounding adds half of the divisor before the right shift. The result never exceeds 255 and always lies between P and C inclusive.
- R7: A frame start sets the line phase to 0. Each later line start advances the phase by one. The phase wraps to 0 after 4 in mode 1 and after 2 in mode 2, so a wrapped phase-0 line outputs the previous line.
- R8: On the first line of a frame there is no previous line, so the current sample stands in for P and the output equals the input.
- R9: The mode is sampled on the pixel that carries the frame marker. A change of the mode input in the middle of a frame has no effect until the next frame start.
- R10: A pixel with the frame marker also starts a line, even if its line marker is low.
- R11: While reset is asserted and directly after it is released, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vmode | input | 2 | Ratio select: 0/3 pass-through, 1 = 4:5, 2 = 2:3 |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input can be accepted (equals out_ready) |
| in_sol | input | 1 | Input pixel is first of a line |
| in_sof | input | 1 | Input pixel is first of a frame |
| in_pix | input | DW | Input sample |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output; advances the pipeline |
| out_sol | output | 1 | Output pixel starts a line |
| out_sof | output | 1 | Output pixel starts a frame |
| out_pix | output | DW | Filtered sample |

## Verification
The only timebase that matters is the count of advancing edges, meaning edges with `out_ready` high. Every result is due exactly two advancing edges after its pixel was accepted, however many stalled edges fall in between. The bench stamps each accepted pixel with the advancing-edge count. On each later advancing edge it expects a valid output exactly when the oldest stamp plus two equals the current count, and it compares sample and markers there; on every other advancing edge it expects `out_valid` low. Inputs and `out_ready` are driven just after the falling edge and sampled one nanosecond later, so every check looks at values that are stable before the rising edge that uses them.

// File: rtl/vlx_pkg.sv
`timescale 1ns/1ps
package vlx_pkg;

  typedef enum logic [1:0] {
    VM_THRU     = 2'd0,
    VM_R45      = 2'd1,
    VM_R23      = 2'd2,
    VM_THRU_ALT = 2'd3
  } vmode_e;

  // highest line phase before the cycle wraps
  function automatic logic [2:0] last_phase(vmode_e m);
    case (m)
      VM_R45:  return 3'd4;
      VM_R23:  return 3'd2;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/vlx_seq.sv
`timescale 1ns/1ps
module vlx_seq
  import vlx_pkg::*;
#(
  parameter int LINE_W = 640,
  parameter int COL_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             sol,
  input  logic             sof,
  input  logic [1:0]       vmode_in,
  output vmode_e           mode_eff,
  output logic [2:0]       phase_eff,
  output logic             first_eff,
  output logic [COL_W-1:0] col_eff
);

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(LINE_W - 1);

  vmode_e           mode_q;
  logic [2:0]       phase_q;
  logic             first_q;
  logic [COL_W-1:0] col_q;

  // position of the pixel now at the input, given its markers
  always_comb begin
    mode_eff  = sof ? vmode_e'(vmode_in) : mode_q;
    phase_eff = phase_q;
    first_eff = first_q;
    col_eff   = (col_q == COL_LAST) ? '0 : col_q + 1'b1;
    if (sof) begin
      phase_eff = 3'd0;
      first_eff = 1'b1;
      col_eff   = '0;
    end else if (sol) begin
      phase_eff = (phase_q >= last_phase(mode_q)) ? 3'd0 : phase_q + 3'd1;
      first_eff = 1'b0;
      col_eff   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= VM_THRU;
      phase_q <= 3'd0;
      first_q <= 1'b1;
      col_q   <= '0;
    end else if (acc) begin
      mode_q  <= mode_eff;
      phase_q <= phase_eff;
      first_q <= first_eff;
      col_q   <= col_eff;
    end
  end

  // R7
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= last_phase(mode_q));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && sof) |=> $stable(mode_q));

endmodule

// File: rtl/vlx_line_store.sv
`timescale 1ns/1ps
module vlx_line_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 640,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // read returns the sample written one line earlier at this column
  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

endmodule

// File: rtl/vlx_blend.sv
`timescale 1ns/1ps
module vlx_blend
  import vlx_pkg::*;
#(
  parameter int DW = 8
) (
  input  vmode_e        mode,
  input  logic [2:0]    phase,
  input  logic [DW-1:0] prev,
  input  logic [DW-1:0] cur,
  output logic [DW-1:0] res
);

  localparam int            SW   = DW + 4;
  localparam logic [DW-1:0] MAXV = {DW{1'b1}};

  logic [2:0]    w_prev, w_cur;
  logic [SW-1:0] sum, scaled;

  always_comb begin
    w_prev = 3'd0;
    w_cur  = 3'd0;
    sum    = '0;
    scaled = SW'(cur);
    case (mode)
      VM_R45: begin
        w_cur  = phase;
        w_prev = 3'd4 - phase;
        sum    = SW'(w_prev) * SW'(prev) + SW'(w_cur) * SW'(cur) + SW'(2);
        scaled = sum >> 2;
      end
      VM_R23: begin
        w_cur  = phase;
        w_prev = 3'd2 - phase;
        sum    = SW'(w_prev) * SW'(prev) + SW'(w_cur) * SW'(cur) + SW'(1);
        scaled = sum >> 1;
      end
      default: scaled = SW'(cur);
    endcase
    res = (scaled > SW'(MAXV)) ? MAXV : scaled[DW-1:0];
  end

endmodule

// File: rtl/vline_expand.sv
`timescale 1ns/1ps
module vline_expand
  import vlx_pkg::*;
#(
  parameter int DW     = 8,
  parameter int LINE_W = 640
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    vmode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sol,
  input  logic          in_sof,
  input  logic [DW-1:0] in_pix,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_sol,
  output logic          out_sof,
  output logic [DW-1:0] out_pix
);

  localparam int COL_W = (LINE_W > 1) ? $clog2(LINE_W) : 1;

  logic             adv, acc;
  vmode_e           mode_eff;
  logic [2:0]       phase_eff;
  logic             first_eff;
  logic [COL_W-1:0] col_eff;
  logic [DW-1:0]    above;

  assign adv      = out_ready;
  assign in_ready = adv;
  assign acc      = in_valid & adv;

  vlx_seq #(.LINE_W(LINE_W), .COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sol(in_sol), .sof(in_sof),
    .vmode_in(vmode), .mode_eff(mode_eff), .phase_eff(phase_eff),
    .first_eff(first_eff), .col_eff(col_eff)
  );

  vlx_line_store #(.DW(DW), .DEPTH(LINE_W), .AW(COL_W)) u_store (
    .clk(clk), .we(acc), .addr(col_eff), .wdata(in_pix), .rdata(above)
  );

  // stage 1: operands and weights selection
  logic          s1_valid, s1_sol, s1_sof;
  logic [DW-1:0] s1_cur, s1_prev;
  vmode_e        s1_mode;
  logic [2:0]    s1_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sol   <= 1'b0;
      s1_sof   <= 1'b0;
      s1_cur   <= '0;
      s1_prev  <= '0;
      s1_mode  <= VM_THRU;
      s1_phase <= 3'd0;
    end else if (adv) begin
      s1_valid <= in_valid;
      s1_sol   <= in_valid & (in_sol | in_sof);
      s1_sof   <= in_valid & in_sof;
      s1_cur   <= in_pix;
      s1_prev  <= first_eff ? in_pix : above;
      s1_mode  <= mode_eff;
      s1_phase <= phase_eff;
    end
  end

  logic [DW-1:0] blend_res;

  vlx_blend #(.DW(DW)) u_blend (
    .mode(s1_mode), .phase(s1_phase), .prev(s1_prev), .cur(s1_cur),
    .res(blend_res)
  );

  // stage 2: output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
      out_sof   <= 1'b0;
      out_pix   <= '0;
    end else if (adv) begin
      out_valid <= s1_valid;
      out_sol   <= s1_sol;
      out_sof   <= s1_sof;
      out_pix   <= blend_res;
    end
  end

  logic [DW-1:0] op_lo, op_hi;
  always_comb begin
    op_lo = (s1_prev < s1_cur) ? s1_prev : s1_cur;
    op_hi = (s1_prev < s1_cur) ? s1_cur : s1_prev;
  end

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) &&
                                   $stable(out_sol) && $stable(out_sof)));

  // R2
  lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && $past(out_ready) && $past(in_valid && out_ready, 2)) |-> out_valid);

  // R6
  blend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> (blend_res >= op_lo && blend_res <= op_hi));

  // R10
  sof_is_sol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> out_sol);

endmodule

// File: tb/vline_expand_test.sv
`timescale 1ns/1ps
module vline_expand_test;

  localparam int DW = 8;
  localparam int LW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    vmode = 2'd0;
  logic          in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
  logic [DW-1:0] in_pix = '0;
  logic          out_ready = 1'b0;
  logic          in_ready, out_valid, out_sol, out_sof;
  logic [DW-1:0] out_pix;

  always #2 clk = ~clk;  // 250 MHz

  vline_expand #(.DW(DW), .LINE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .vmode(vmode),
    .in_valid(in_valid), .in_ready(in_ready), .in_sol(in_sol), .in_sof(in_sof),
    .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready),
    .out_sol(out_sol), .out_sof(out_sof), .out_pix(out_pix)
  );

  int checks = 0, fails = 0, cnt = 0;
  bit done = 1'b0;
  bit rdy_always = 1'b1;
  string ftag = "";

  int    q_stamp[$];
  int    q_pix[$];
  int    q_sol[$];
  int    q_sof[$];
  string q_tag[$];

  int m_line[LW];
  int m_mode = 0, m_ph = 0, m_first = 1, m_col = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int mdl_blend(int p, int c, int m, int k);
    int r;
    if (m == 1) r = ((4 - k) * p + k * c + 2) >> 2;
    else if (m == 2) r = ((2 - k) * p + k * c + 1) >> 1;
    else r = c;
    return (r > 255) ? 255 : r;
  endfunction

  task automatic model_accept();
    int d, p, e, n;
    string tg;
    d = int'(in_pix);
    if (in_sof) begin
      m_mode = int'(vmode); m_ph = 0; m_first = 1; m_col = 0;
    end else if (in_sol) begin
      n = (m_mode == 1) ? 5 : (m_mode == 2) ? 3 : 1;
      m_ph = (m_ph + 1) % n; m_first = 0; m_col = 0;
    end else begin
      m_col = (m_col + 1) % LW;
    end
    p = m_first ? d : m_line[m_col];
    e = mdl_blend(p, d, m_mode, m_ph);
    m_line[m_col] = d;
    if (ftag != "") tg = ftag;
    else if (m_first != 0) tg = "R8";
    else if (m_mode == 0 || m_mode == 3) tg = "R3";
    else if (m_ph == 0) tg = "R7";
    else if (m_mode == 1 && (((4 - m_ph) * p + m_ph * d) % 4) != 0) tg = "R6";
    else if (m_mode == 2 && (((2 - m_ph) * p + m_ph * d) % 2) != 0) tg = "R6";
    else if (m_mode == 1) tg = "R4";
    else tg = "R5";
    q_stamp.push_back(cnt);
    q_pix.push_back(e);
    q_sol.push_back((in_sol || in_sof) ? 1 : 0);
    q_sof.push_back(in_sof ? 1 : 0);
    q_tag.push_back(tg);
  endtask

  // one clock: drive after the falling edge, evaluate before the rising edge
  task automatic cycle(input logic v, input logic sl, input logic sf,
                       input logic [DW-1:0] d, output bit accepted);
    @(negedge clk);
    in_valid  = v;
    in_sol    = sl;
    in_sof    = sf;
    in_pix    = d;
    out_ready = rdy_always ? 1'b1 : (($urandom % 4) != 0);
    #1;
    chk(in_ready === out_ready, "R1", "in_ready", int'(in_ready), int'(out_ready));
    accepted = v && out_ready;
    if (out_ready) begin
      if (q_stamp.size() > 0 && q_stamp[0] + 2 == cnt) begin
        chk(out_valid === 1'b1, "R2", "out_valid", int'(out_valid), 1);
        chk(int'(out_pix) == q_pix[0], q_tag[0], "out_pix", int'(out_pix), q_pix[0]);
        chk(int'(out_sol) == q_sol[0] && int'(out_sof) == q_sof[0], "R2", "markers",
            int'({out_sol, out_sof}), q_sol[0] * 2 + q_sof[0]);
        void'(q_stamp.pop_front());
        void'(q_pix.pop_front());
        void'(q_sol.pop_front());
        void'(q_sof.pop_front());
        void'(q_tag.pop_front());
      end else begin
        chk(out_valid === 1'b0, "R2", "idle out_valid", int'(out_valid), 0);
      end
      if (v) model_accept();
      cnt++;
    end
  endtask

  function automatic logic [DW-1:0] pat_pix(int pat, int l, int c);
    case (pat)
      1:       return (l % 2 != 0) ? 8'd255 : 8'd0;
      2:       return DW'((l + c) % 2);
      3:       return 8'd255;
      default: return DW'($urandom % 256);
    endcase
  endfunction

  task automatic send_frame(int mode, int nlines, int len, int pat,
                            bit sof_no_sol, int switch_line, string tag);
    bit acc;
    logic [DW-1:0] d;
    ftag = tag;
    vmode = 2'(mode);
    for (int l = 0; l < nlines; l++) begin
      if (l == switch_line) vmode = 2'((mode == 1) ? 2 : 1);
      for (int c = 0; c < len; c++) begin
        d = pat_pix(pat, l, c);
        if (!rdy_always && ($urandom % 4) == 0) cycle(1'b0, 1'b0, 1'b0, 8'd0, acc);
        acc = 1'b0;
        while (!acc)
          cycle(1'b1, (c == 0) && !(l == 0 && sof_no_sol), (l == 0 && c == 0), d, acc);
      end
    end
    ftag = "";
    vmode = 2'(mode);
  endtask

  initial begin
    bit acc;
    void'($urandom(32'h5eed));
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      out_ready = 1'b1;
      #1;
      chk(out_valid === 1'b0, "R11", "out_valid in reset", int'(out_valid), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid === 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);

    rdy_always = 1'b1;
    send_frame(1, 7, LW, 0, 1'b0, -1, "");
    rdy_always = 1'b0;
    send_frame(0, 4, LW, 0, 1'b0, -1, "");
    send_frame(1, 7, LW, 1, 1'b0, -1, "");
    send_frame(1, 11, LW, 2, 1'b0, -1, "");
    send_frame(2, 7, LW, 0, 1'b0, -1, "");
    send_frame(2, 5, LW, 2, 1'b0, -1, "");
    send_frame(3, 3, LW, 0, 1'b0, -1, "");
    send_frame(1, 6, LW, 3, 1'b0, -1, "");
    send_frame(1, 8, LW, 0, 1'b0, 2, "R9");
    send_frame(2, 4, LW, 0, 1'b1, -1, "R10");
    send_frame(1, 7, 5, 0, 1'b0, -1, "");
    send_frame(2, 6, LW, 1, 1'b0, -1, "");
    rdy_always = 1'b1;
    repeat (6) cycle(1'b0, 1'b0, 1'b0, 8'd0, acc);
    chk(q_stamp.size() == 0, "R2", "pending outputs", q_stamp.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule